// File: doc/BRIEF.md
# Dual Alarm Monitor with Level and Rate-of-Change Detection

This block watches sensor data for two independent alarm conditions. On every sample strobe each of its two channels takes one 16-bit two's-complement word from a chosen source: the angular rate word, the temperature word or the system status word. One input bit decides whether the rate and temperature words come from the filtered or the unfiltered data path. A channel in level mode compares the word itself against a signed threshold. A channel in rate-of-change mode takes the current word minus the word seen a programmable number of strobes earlier and compares that difference against the threshold. A per-channel direction bit picks whether the alarm trips above or below the threshold.

A tripped channel sets a sticky flag in a 16-bit status word. Reading the status word clears the flags. A flag comes back at the next strobe if its condition still holds. The OR of the two flags forms an alarm indicator. The indicator can be placed on one of two output pins with a chosen polarity. Each pin is shared with a data-ready pulse and with a general-purpose output under a fixed priority. All configuration arrives on plain input ports, so register decoding is left to the surrounding logic.

Top module: `dual_alarm_mon`

## Requirements
- R1: Source code 1 selects the rate word, 2 selects the temperature word and 3 selects the system status word. Code 0 and codes 4 to 15 disable the channel, which then never trips.
- R2: With `use_filt` = 1 the rate and temperature sources come from the filtered inputs, and with 0 from the raw inputs. The system status source does not depend on `use_filt`.
- R3: In level mode (`chN_rate_mode` = 0) the channel compares the selected word as a signed number against the signed threshold. The comparison is strict, so equality never trips.
- R4: With `chN_above` = 1 the channel trips when the compared value is greater than the threshold. With 0 it trips when the compared value is less than the threshold.
- R5: In rate-of-change mode (`chN_rate_mode` = 1) the compared value is the current word minus the word taken N strobes earlier. The difference is formed as a signed 17-bit value without wrap and compared with the sign-extended threshold. N is `chN_win`, and a window of 0 or of 1 both mean one strobe.
- R6: In rate-of-change mode a channel cannot trip until it has stored at least N words since reset or since it was last disabled.
- R7: A channel that trips during a strobe sets its flag on the next clock edge. Channel 0 drives status bit 8 and channel 1 drives bit 9, where 1 means active. All other status bits read 0.
- R8: A cycle with `stat_rd` = 1 clears both flags on the next edge. A trip in the same cycle as the read wins, and its flag stays set.
- R9: A flag holds until it is read, even if the condition goes away. After a read it becomes 1 again at the next strobe while the condition still holds.
- R10: For each of the two pins the owner is chosen by priority. Data-ready comes first when `drdy_en` = 1 and `drdy_pin` names the pin. The alarm indicator comes next when `ind_en` = 1 and `ind_pin` names the pin. Otherwise the pin follows `gpio_oe`/`gpio_val`.
- R11: The alarm indicator is active while either flag is set. With `ind_act_hi` = 1 the active level is 1, and with 0 it is 0. Data-ready follows `drdy_in` with the same polarity rule using `drdy_act_hi`.
- R12: The pin outputs are registered and change one clock after their inputs. A pin owned by data-ready or by the indicator is always driven. A general-purpose pin is driven only when its `gpio_oe` bit is 1, and it reads 0 when not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_stb | input | 1 | One-cycle sample strobe |
| use_filt | input | 1 | 1 selects filtered rate and temperature |
| rate_raw | input | 16 | Unfiltered rate word |
| rate_filt | input | 16 | Filtered rate word |
| temp_raw | input | 16 | Unfiltered temperature word |
| temp_filt | input | 16 | Filtered temperature word |
| sys_status | input | 16 | System status word source |
| ch0_src_sel | input | 4 | Channel 0 source code |
| ch0_rate_mode | input | 1 | Channel 0 rate-of-change mode |
| ch0_above | input | 1 | Channel 0 trips above (1) or below (0) |
| ch0_thresh | input | 16 | Channel 0 signed threshold |
| ch0_win | input | 8 | Channel 0 window in strobes |
| ch1_src_sel | input | 4 | Channel 1 source code |
| ch1_rate_mode | input | 1 | Channel 1 rate-of-change mode |
| ch1_above | input | 1 | Channel 1 trips above (1) or below (0) |
| ch1_thresh | input | 16 | Channel 1 signed threshold |
| ch1_win | input | 8 | Channel 1 window in strobes |
| stat_rd | input | 1 | Status read, clears the flags |
| stat_word | output | 16 | Status word, flags at bits 8 and 9 |
| drdy_in | input | 1 | Data-ready pulse |
| drdy_en | input | 1 | Data-ready output enable |
| drdy_pin | input | 1 | Pin used for data-ready |
| drdy_act_hi | input | 1 | Data-ready active level |
| ind_en | input | 1 | Alarm indicator enable |
| ind_pin | input | 1 | Pin used for the indicator |
| ind_act_hi | input | 1 | Indicator active level |
| gpio_oe | input | 2 | General-purpose drive enables |
| gpio_val | input | 2 | General-purpose levels |
| pin_out | output | 2 | Pin levels |
| pin_oe | output | 2 | Pin drive enables |

## Verification
The hardest situation to reach is a rate-of-change trip that depends on a word stored several strobes earlier, together with the fill gate that must block a trip until the window is full. The stimulus first disables the channel to empty its history. It then feeds a known ramp with a window of three and reads the status after every strobe. This shows that the first words cannot trip and that a later trip tracks the word exactly three strobes back. Separate runs with window 0 and window 1, and a full-scale jump whose difference needs the seventeenth bit, pin down the window decoding and the wrap-free subtraction.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;

    localparam int SRC_SEL_W = 4;

    typedef enum logic [SRC_SEL_W-1:0] {
        SRC_OFF  = 4'd0,
        SRC_RATE = 4'd1,
        SRC_TEMP = 4'd2,
        SRC_STAT = 4'd3
    } src_code_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_drv_t;

    function automatic logic src_is_live(input logic [SRC_SEL_W-1:0] code);
        return (code == SRC_RATE) || (code == SRC_TEMP) || (code == SRC_STAT);
    endfunction

endpackage

// File: rtl/alarm_hist.sv
module alarm_hist #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 255,
    parameter int WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              flush,
    input  logic [DATA_W-1:0] din,
    input  logic [WIN_W-1:0]  span,
    output logic [DATA_W-1:0] past,
    output logic              ready
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [FILL_W-1:0] fill;
    } hist_st_t;

    hist_st_t          st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_idx;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wptr = (32'(st_q.wptr) == DEPTH - 1) ? '0 : st_q.wptr + 1'b1;
            if (32'(st_q.fill) < DEPTH) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
        if (flush) begin
            st_d.fill = '0;
        end
        if (32'(st_q.wptr) >= 32'(span)) begin
            rd_idx = PTR_W'(32'(st_q.wptr) - 32'(span));
        end else begin
            rd_idx = PTR_W'(32'(st_q.wptr) + 32'(DEPTH) - 32'(span));
        end
        ready = 32'(st_q.fill) >= 32'(span);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[st_q.wptr] <= din;
        end
    end

    assign past = mem[rd_idx];

endmodule

// File: rtl/alarm_chan.sv
module alarm_chan
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int HIST_DEPTH = 255,
    parameter int WIN_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic                 rate_mode,
    input  logic                 above,
    input  logic [DATA_W-1:0]    thresh,
    input  logic [WIN_W-1:0]     win,
    input  logic [DATA_W-1:0]    rate_w,
    input  logic [DATA_W-1:0]    temp_w,
    input  logic [DATA_W-1:0]    stat_w,
    output logic                 trip
);
    logic                     active;
    logic [DATA_W-1:0]        cur;
    logic [DATA_W-1:0]        past;
    logic [WIN_W-1:0]         span;
    logic                     hist_ready;
    logic signed [DATA_W:0]   cur_x, past_x, thr_x, delta, probe;
    logic                     level_hit;

    always_comb begin
        case (src_sel)
            SRC_RATE: cur = rate_w;
            SRC_TEMP: cur = temp_w;
            SRC_STAT: cur = stat_w;
            default:  cur = '0;
        endcase
        active    = src_is_live(src_sel);
        span      = (win <= WIN_W'(1)) ? WIN_W'(1) : win;
        cur_x     = $signed({cur[DATA_W-1], cur});
        past_x    = $signed({past[DATA_W-1], past});
        thr_x     = $signed({thresh[DATA_W-1], thresh});
        delta     = cur_x - past_x;
        probe     = rate_mode ? delta : cur_x;
        level_hit = above ? (probe > thr_x) : (probe < thr_x);
        trip      = active && level_hit && (!rate_mode || hist_ready);
    end

    alarm_hist #(
        .DATA_W(DATA_W),
        .DEPTH (HIST_DEPTH),
        .WIN_W (WIN_W)
    ) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .push (stb && active),
        .flush(!active),
        .din  (cur),
        .span (span),
        .past (past),
        .ready(hist_ready)
    );

endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux
    import alarm_mon_pkg::*;
#(
    parameter int NPIN = 2,
    parameter int PSEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_in,
    input  logic              drdy_en,
    input  logic [PSEL_W-1:0] drdy_pin,
    input  logic              drdy_act_hi,
    input  logic              alarm_any,
    input  logic              ind_en,
    input  logic [PSEL_W-1:0] ind_pin,
    input  logic              ind_act_hi,
    input  logic [NPIN-1:0]   gpio_oe,
    input  logic [NPIN-1:0]   gpio_val,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    pin_drv_t [NPIN-1:0] drv_d, drv_q;

    always_comb begin
        for (int p = 0; p < NPIN; p++) begin
            if (drdy_en && (32'(drdy_pin) == p)) begin
                drv_d[p] = '{drive: 1'b1, level: drdy_in ~^ drdy_act_hi};
            end else if (ind_en && (32'(ind_pin) == p)) begin
                drv_d[p] = '{drive: 1'b1, level: alarm_any ~^ ind_act_hi};
            end else begin
                drv_d[p] = '{drive: gpio_oe[p], level: gpio_oe[p] & gpio_val[p]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            assign pin_out[g] = drv_q[g].level;
            assign pin_oe[g]  = drv_q[g].drive;
        end
    endgenerate

endmodule

// File: rtl/dual_alarm_mon.sv
module dual_alarm_mon
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int HIST_DEPTH = 255,
    parameter int WIN_W      = 8,
    parameter int NPIN       = 2,
    parameter int FLAG_LSB   = 8,
    parameter int PSEL_W     = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic                 use_filt,
    input  logic [DATA_W-1:0]    rate_raw,
    input  logic [DATA_W-1:0]    rate_filt,
    input  logic [DATA_W-1:0]    temp_raw,
    input  logic [DATA_W-1:0]    temp_filt,
    input  logic [DATA_W-1:0]    sys_status,
    input  logic [SRC_SEL_W-1:0] ch0_src_sel,
    input  logic                 ch0_rate_mode,
    input  logic                 ch0_above,
    input  logic [DATA_W-1:0]    ch0_thresh,
    input  logic [WIN_W-1:0]     ch0_win,
    input  logic [SRC_SEL_W-1:0] ch1_src_sel,
    input  logic                 ch1_rate_mode,
    input  logic                 ch1_above,
    input  logic [DATA_W-1:0]    ch1_thresh,
    input  logic [WIN_W-1:0]     ch1_win,
    input  logic                 stat_rd,
    output logic [DATA_W-1:0]    stat_word,
    input  logic                 drdy_in,
    input  logic                 drdy_en,
    input  logic [PSEL_W-1:0]    drdy_pin,
    input  logic                 drdy_act_hi,
    input  logic                 ind_en,
    input  logic [PSEL_W-1:0]    ind_pin,
    input  logic                 ind_act_hi,
    input  logic [NPIN-1:0]      gpio_oe,
    input  logic [NPIN-1:0]      gpio_val,
    output logic [NPIN-1:0]      pin_out,
    output logic [NPIN-1:0]      pin_oe
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0] flag;
    } mon_st_t;

    mon_st_t              st_d, st_q;
    logic [DATA_W-1:0]    rate_w, temp_w;
    logic [NCH-1:0]       trip;
    logic [SRC_SEL_W-1:0] src_a  [NCH];
    logic                 mode_a [NCH];
    logic                 abv_a  [NCH];
    logic [DATA_W-1:0]    thr_a  [NCH];
    logic [WIN_W-1:0]     win_a  [NCH];

    assign rate_w = use_filt ? rate_filt : rate_raw;
    assign temp_w = use_filt ? temp_filt : temp_raw;

    assign src_a[0]  = ch0_src_sel;
    assign src_a[1]  = ch1_src_sel;
    assign mode_a[0] = ch0_rate_mode;
    assign mode_a[1] = ch1_rate_mode;
    assign abv_a[0]  = ch0_above;
    assign abv_a[1]  = ch1_above;
    assign thr_a[0]  = ch0_thresh;
    assign thr_a[1]  = ch1_thresh;
    assign win_a[0]  = ch0_win;
    assign win_a[1]  = ch1_win;

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chan
            alarm_chan #(
                .DATA_W    (DATA_W),
                .HIST_DEPTH(HIST_DEPTH),
                .WIN_W     (WIN_W)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .stb      (sample_stb),
                .src_sel  (src_a[k]),
                .rate_mode(mode_a[k]),
                .above    (abv_a[k]),
                .thresh   (thr_a[k]),
                .win      (win_a[k]),
                .rate_w   (rate_w),
                .temp_w   (temp_w),
                .stat_w   (sys_status),
                .trip     (trip[k])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & {NCH{~stat_rd}}) | (trip & {NCH{sample_stb}});
        stat_word = '0;
        stat_word[FLAG_LSB +: NCH] = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    alarm_pin_mux #(
        .NPIN  (NPIN),
        .PSEL_W(PSEL_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_in    (drdy_in),
        .drdy_en    (drdy_en),
        .drdy_pin   (drdy_pin),
        .drdy_act_hi(drdy_act_hi),
        .alarm_any  (|st_q.flag),
        .ind_en     (ind_en),
        .ind_pin    (ind_pin),
        .ind_act_hi (ind_act_hi),
        .gpio_oe    (gpio_oe),
        .gpio_val   (gpio_val),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

endmodule

// File: rtl/dual_alarm_mon_chk.sv
module dual_alarm_mon_chk #(
    parameter int DATA_W   = 16,
    parameter int FLAG_LSB = 8,
    parameter int NPIN     = 2,
    parameter int PSEL_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_stb,
    input logic              stat_rd,
    input logic [3:0]        ch0_src_sel,
    input logic [1:0]        trip,
    input logic [DATA_W-1:0] stat_word,
    input logic              drdy_in,
    input logic              drdy_en,
    input logic [PSEL_W-1:0] drdy_pin,
    input logic              drdy_act_hi,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe
);
    // R1: a disabled channel never reports a trip
    a_r1_off_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_src_sel == 4'd0) |-> !trip[0]);

    // R7: a trip during a strobe sets the matching status bit
    a_r7_ch0_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && trip[0]) |=> stat_word[FLAG_LSB]);
    a_r7_ch1_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && trip[1]) |=> stat_word[FLAG_LSB+1]);

    // R8: a read with no strobe empties the status word
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sample_stb) |=> (stat_word == '0));

    // R9: the flag stays set until read and does not rise without a trip
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[FLAG_LSB] && !stat_rd) |=> stat_word[FLAG_LSB]);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_word[FLAG_LSB] && !(sample_stb && trip[0])) |=> !stat_word[FLAG_LSB]);

    // R10: data-ready owns pin 0 when routed there
    a_r10_drdy_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_en && drdy_pin == '0) |=>
            (pin_oe[0] && (pin_out[0] == $past(drdy_in ~^ drdy_act_hi))));
endmodule

bind dual_alarm_mon dual_alarm_mon_chk #(
    .DATA_W  (DATA_W),
    .FLAG_LSB(FLAG_LSB),
    .NPIN    (NPIN),
    .PSEL_W  (PSEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .stat_rd    (stat_rd),
    .ch0_src_sel(ch0_src_sel),
    .trip       (trip),
    .stat_word  (stat_word),
    .drdy_in    (drdy_in),
    .drdy_en    (drdy_en),
    .drdy_pin   (drdy_pin),
    .drdy_act_hi(drdy_act_hi),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/dual_alarm_mon_bench.sv
module dual_alarm_mon_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0, use_filt = 1'b0;
    logic [15:0] rate_raw = '0, rate_filt = '0, temp_raw = '0, temp_filt = '0, sys_status = '0;
    logic [3:0]  ch0_src_sel = '0, ch1_src_sel = '0;
    logic        ch0_rate_mode = 1'b0, ch0_above = 1'b0, ch1_rate_mode = 1'b0, ch1_above = 1'b0;
    logic [15:0] ch0_thresh = '0, ch1_thresh = '0;
    logic [7:0]  ch0_win = '0, ch1_win = '0;
    logic        stat_rd = 1'b0;
    logic [15:0] stat_word;
    logic        drdy_in = 1'b0, drdy_en = 1'b0, drdy_pin = 1'b0, drdy_act_hi = 1'b0;
    logic        ind_en = 1'b0, ind_pin = 1'b0, ind_act_hi = 1'b0;
    logic [1:0]  gpio_oe = '0, gpio_val = '0;
    logic [1:0]  pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dual_alarm_mon u_dual_alarm_mon (.*);

    typedef struct packed {
        logic [3:0]  src;
        logic        above;
        logic [15:0] thr;
        logic [15:0] rate;
        logic [15:0] temp;
        logic        exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 1'b1, 16'd100,   16'd101,   16'd0,   1'b1},  // R3 R4 above
        '{4'd1, 1'b1, 16'd100,   16'd100,   16'd0,   1'b0},  // R3 equal is no trip
        '{4'd1, 1'b0, 16'd100,   16'd99,    16'd0,   1'b1},  // R4 below
        '{4'd1, 1'b0, 16'hFFFB,  16'hFFFA,  16'd0,   1'b1},  // R3 signed -6 < -5
        '{4'd1, 1'b1, 16'hFFFB,  16'h7FFF,  16'd0,   1'b1},  // R3 signed max > -5
        '{4'd2, 1'b1, 16'd1000,  16'd5000,  16'd999, 1'b0},  // R1 temp chosen
        '{4'd2, 1'b0, 16'd1000,  16'd5000,  16'd999, 1'b1},  // R1 temp below
        '{4'd0, 1'b1, 16'd0,     16'h7FFF,  16'd0,   1'b0},  // R1 off
        '{4'hA, 1'b1, 16'd0,     16'd10,    16'd0,   1'b0},  // R1 reserved code
        '{4'd3, 1'b1, 16'h0010,  16'd0,     16'd0,   1'b1},  // R1 status source
        '{4'd3, 1'b0, 16'h0010,  16'd0,     16'd0,   1'b0}   // R1 status below
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic read_stat(output logic [15:0] v);
        v = stat_word;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic rate_step(input logic [15:0] val, input logic exp, input string tag);
        logic [15:0] v;
        rate_raw = val;
        strobe();
        read_stat(v);
        chk(tag, 32'(v[8]), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R7 reset status", 32'(stat_word), 32'h0);
        chk("R12 reset pin_oe", 32'(pin_oe), 32'h0);
        chk("R12 reset pin_out", 32'(pin_out), 32'h0);

        // table of level-mode vectors on channel 0, raw data
        sys_status = 16'h0020;
        rate_filt  = 16'h7FFF;
        for (int i = 0; i < NVEC; i++) begin
            ch0_src_sel = VECS[i].src;
            ch0_above   = VECS[i].above;
            ch0_thresh  = VECS[i].thr;
            rate_raw    = VECS[i].rate;
            temp_raw    = VECS[i].temp;
            strobe();
            read_stat(v);
            chk($sformatf("R3/R1 vector %0d bit8", i), 32'(v[8]), 32'(VECS[i].exp));
            chk($sformatf("R7 vector %0d other bits", i), 32'(v & 16'hFEFF), 32'h0);
        end
        chk("R8 cleared after read", 32'(stat_word), 32'h0);

        // R2 filtered versus raw
        ch0_src_sel = 4'd1; ch0_above = 1'b1; ch0_thresh = 16'd100;
        rate_raw = 16'd0; rate_filt = 16'd200; use_filt = 1'b1;
        strobe(); read_stat(v);
        chk("R2 filtered rate", 32'(v[8]), 32'h1);
        use_filt = 1'b0;
        strobe(); read_stat(v);
        chk("R2 raw rate", 32'(v[8]), 32'h0);
        use_filt = 1'b1; ch0_src_sel = 4'd3; ch0_thresh = 16'h0010;
        strobe(); read_stat(v);
        chk("R2 status ignores filter select", 32'(v[8]), 32'h1);
        use_filt = 1'b0;

        // R5 R6 rate-of-change, window 3
        ch0_src_sel = 4'd0; tick(1);
        ch0_src_sel = 4'd1; ch0_rate_mode = 1'b1; ch0_above = 1'b1;
        ch0_thresh = 16'd50; ch0_win = 8'd3;
        rate_step(16'd0,   1'b0, "R6 fill 0");
        rate_step(16'd10,  1'b0, "R6 fill 1");
        rate_step(16'd20,  1'b0, "R6 fill 2");
        rate_step(16'd100, 1'b1, "R5 diff 100-0");
        rate_step(16'd110, 1'b1, "R5 diff 110-10");
        rate_step(16'd60,  1'b0, "R5 diff 60-20");
        // R6 disabling empties the history
        ch0_src_sel = 4'd0; tick(1); ch0_src_sel = 4'd1;
        rate_step(16'd900, 1'b0, "R6 after re-enable");

        // R5 window 0 and 1 both mean one strobe
        for (int w = 0; w < 2; w++) begin
            ch0_src_sel = 4'd0; tick(1); ch0_src_sel = 4'd1;
            ch0_win = 8'(w); ch0_thresh = 16'd5;
            rate_step(16'd0,  1'b0, "R6 window short fill");
            rate_step(16'd10, 1'b1, "R5 window short trip");
            rate_step(16'd12, 1'b0, "R5 window short small");
        end
        // R5 negative change with below polarity
        ch0_above = 1'b0; ch0_thresh = 16'hFFCE;  // -50
        rate_step(16'd100, 1'b0, "R5 drop +88");
        rate_step(16'd20,  1'b1, "R5 drop -80");
        // R5 difference needs 17 bits
        ch0_above = 1'b1; ch0_thresh = 16'd100;
        rate_step(16'h8000, 1'b0, "R5 jump base");
        rate_step(16'h7FFF, 1'b1, "R5 full-scale jump no wrap");

        // R8 R9 sticky and read behaviour, level mode
        ch0_rate_mode = 1'b0; ch0_thresh = 16'd100; rate_raw = 16'd500;
        strobe();
        chk("R7 flag one edge after strobe", 32'(stat_word), 32'h0100);
        rate_raw = 16'd0;
        strobe();
        chk("R9 flag held without condition", 32'(stat_word[8]), 32'h1);
        rate_raw = 16'd500;
        sample_stb = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; stat_rd = 1'b0;
        chk("R8 trip wins over same-cycle read", 32'(stat_word[8]), 32'h1);
        read_stat(v);
        chk("R8 cleared after plain read", 32'(stat_word), 32'h0);
        strobe();
        chk("R9 re-asserts while condition holds", 32'(stat_word[8]), 32'h1);
        read_stat(v);
        ch0_src_sel = 4'd0;

        // R7 channel 1 uses bit 9
        ch1_src_sel = 4'd2; ch1_above = 1'b1; ch1_thresh = 16'd0; temp_raw = 16'd5;
        strobe(); read_stat(v);
        chk("R7 channel 1 bit 9", 32'(v), 32'h0200);
        ch1_src_sel = 4'd0;
        tick(1);

        // R10 R11 R12 pin sharing
        gpio_oe = 2'b11; gpio_val = 2'b10; tick(1);
        chk("R12 gpio oe", 32'(pin_oe), 32'h3);
        chk("R12 gpio level", 32'(pin_out), 32'h2);
        gpio_oe = 2'b01; tick(1);
        chk("R12 undriven pin reads 0", 32'(pin_out), 32'h0);
        chk("R12 undriven pin oe", 32'(pin_oe), 32'h1);
        ind_en = 1'b1; ind_pin = 1'b0; ind_act_hi = 1'b1; tick(1);
        chk("R11 indicator idle high-active", 32'(pin_out[0]), 32'h0);
        ind_act_hi = 1'b0; tick(1);
        chk("R11 indicator idle low-active", 32'(pin_out[0]), 32'h1);
        ind_act_hi = 1'b1;
        ch1_src_sel = 4'd2;
        strobe(); tick(1);
        chk("R11 indicator shows alarm", 32'(pin_out[0]), 32'h1);
        ch1_src_sel = 4'd0;
        drdy_en = 1'b1; drdy_pin = 1'b0; drdy_act_hi = 1'b1; drdy_in = 1'b0; tick(1);
        chk("R10 data-ready over alarm", 32'(pin_out[0]), 32'h0);
        drdy_in = 1'b1; tick(1);
        chk("R10 data-ready level", 32'(pin_out[0]), 32'h1);
        drdy_in = 1'b0; ind_pin = 1'b1; tick(1);
        chk("R10 indicator over gpio on pin 1", 32'(pin_out), 32'h2);
        chk("R10 both pins driven", 32'(pin_oe), 32'h3);
        drdy_en = 1'b0; ind_en = 1'b0; gpio_oe = 2'b11; gpio_val = 2'b01; tick(1);
        chk("R10 gpio when pins free", 32'(pin_out), 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule